// File: doc/BRIEF.md
# Critical-Word-First Refill Controller

This block controls refills for a 4-way set-associative L1 data cache with 64-byte lines. It handles one load at a time. When a load arrives, the block compares its address against the tags of the indexed set. On a hit it returns the 64-bit word on the next cycle.

On a miss it does the following:
- It picks a victim way and sends a line request to the next memory level. The request carries the index of the 128-bit beat that holds the missed word.
- The memory side returns four beats. They start with that critical beat and wrap through the line.
- The block hands the missed word to the load path in the cycle after the critical beat arrives, so the load completes before the line is whole.
- Every beat is written into the victim way as it arrives.
- The tag and valid bit of the way are written together with the fourth beat.

New requests are held off while a fill is in progress.

The controller is a three-state machine:
- `S_IDLE` accepts requests and answers hits.
- `S_ISSUE` holds the line request until the memory side takes it.
- `S_FILL` counts beats.

The transitions are:
- `S_IDLE` to `S_ISSUE` when a miss is accepted.
- `S_ISSUE` to `S_FILL` when `mem_req_ready` is seen.
- `S_FILL` to `S_IDLE` when the fourth beat is taken.
- A hit keeps the machine in `S_IDLE`.

Top module: `l1d_refill_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0, and every way of every set is invalid, so the first access to any line misses.
- R2: The address is split as follows, and both the lookup and the returned data follow these fields.
  - Byte offset: bits [5:0].
  - Set index: the next log2(SETS) bits, which is bits [12:6] at the default of 128 sets.
  - Tag: all bits above the index.
  - Beat within the line: bits [5:4].
  - 64-bit half within the beat: bit 3, where 0 selects bits [63:0] and 1 selects bits [127:64].
- R3: When a request is accepted (`req_valid` and `req_ready` both high at a clock edge) and its line is resident, the following happen on the next cycle:
  - `rsp_valid` is 1.
  - `rsp_data` holds the addressed 64-bit word.
  - `mem_req_valid` stays 0.
- R4: When a request is accepted and its line is not resident, `mem_req_valid` rises on the next cycle. `mem_req_line` carries address bits [ADDR_W-1:6] and `mem_req_crit` carries address bits [5:4]. Both stay stable until a clock edge where `mem_req_ready` is high, and `mem_req_valid` falls after that edge.
- R5: Beats are taken on edges where `mem_beat_valid` is high, with any number of idle cycles between them. Beat n (n = 0..3) is stored at line position (crit + n) mod 4 of the chosen way.
- R6: `rsp_valid` is 1 in exactly one cycle per fill: the cycle after the first beat is taken. `rsp_data` then holds the half of that beat selected by address bit 3.
- R7: The victim way is chosen as follows:
  - If any way of the set is invalid, the lowest-numbered invalid way is the victim.
  - Otherwise a 2-bit round-robin counter kept for each set names the victim.
  - The counter starts at 0 and advances on every fill into its set.
- R8: Tag and valid are written on the edge that takes the fourth beat. From the next cycle on, loads to the line hit.
- R9: `req_ready` is 0 from the cycle after a miss is accepted until the fourth beat has been taken. No request is accepted in that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Byte address of the load |
| rsp_valid | output | 1 | Load data valid this cycle |
| rsp_data | output | WORD_W | Returned 64-bit word |
| mem_req_valid | output | 1 | Line request to the next level |
| mem_req_ready | input | 1 | Next level takes the request |
| mem_req_line | output | ADDR_W-6 | Line address of the request |
| mem_req_crit | output | log2(beats) | Index of the critical beat |
| mem_beat_valid | input | 1 | Refill beat present |
| mem_beat_data | input | BEAT_W | Refill beat payload |

## Verification
The bench builds the block with `ADDR_W=16` and `SETS=4`. This leaves an 8-bit tag and only four sets, so a short run over a few tags fills every way of a set and reaches round-robin eviction many times over. The reference model predicts every hit, miss and victim choice on that basis. Critical beats at all four positions, both word halves, held-off line requests, gaps between beats and requests held during a fill all occur under these values.

// File: rtl/l1d_refill_pkg.sv
package l1d_refill_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_FILL  = 2'd2
    } fill_state_e;
endpackage

// File: rtl/l1d_tag_store.sv
module l1d_tag_store #(
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int TAG_W = 19,
    parameter int IDX_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_hit_way,
    output logic [WAY_W-1:0] lk_victim,
    input  logic             ins_en,
    input  logic [IDX_W-1:0] ins_idx,
    input  logic [WAY_W-1:0] ins_way,
    input  logic [TAG_W-1:0] ins_tag
);
    localparam logic [WAY_W-1:0] RR_STEP = WAY_W'(1);

    logic [WAYS-1:0]  valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAY_W-1:0] rr_q    [SETS];
    logic [WAYS-1:0]  row_valid;
    logic [WAYS-1:0]  hit_vec;

    assign row_valid = valid_q[lk_idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = row_valid[w] && (tag_q[lk_idx][w] == lk_tag);
    end

    assign lk_hit = |hit_vec;

    always_comb begin
        lk_hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) lk_hit_way = WAY_W'(w);
        end
    end

    // lowest invalid way first, otherwise the set's rotating pointer
    always_comb begin
        logic found;
        found     = 1'b0;
        lk_victim = rr_q[lk_idx];
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !row_valid[w]) begin
                lk_victim = WAY_W'(w);
                found     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                rr_q[s]    <= '0;
            end
        end else if (ins_en) begin
            valid_q[ins_idx][ins_way] <= 1'b1;
            rr_q[ins_idx]             <= rr_q[ins_idx] + RR_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) tag_q[ins_idx][ins_way] <= ins_tag;
    end

    // R3: a line is resident in at most one way
    a_r3_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R7: an invalid way is always taken before any valid one
    a_r7_victim_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&row_valid)) |-> !row_valid[lk_victim]);
endmodule

// File: rtl/l1d_line_data.sv
module l1d_line_data #(
    parameter int SETS    = 128,
    parameter int WAYS    = 4,
    parameter int BEATS   = 4,
    parameter int BEAT_W  = 128,
    parameter int IDX_W   = $clog2(SETS),
    parameter int WAY_W   = $clog2(WAYS),
    parameter int BEAT_IW = $clog2(BEATS)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WAY_W-1:0]   wr_way,
    input  logic [BEAT_IW-1:0] wr_beat,
    input  logic [BEAT_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [WAY_W-1:0]   rd_way,
    input  logic [BEAT_IW-1:0] rd_beat,
    output logic [BEAT_W-1:0]  rd_data
);
    localparam int DEPTH = SETS * WAYS * BEATS;

    logic [BEAT_W-1:0] store_q [DEPTH];

    assign rd_data = store_q[{rd_idx, rd_way, rd_beat}];

    always_ff @(posedge clk) begin
        if (wr_en) store_q[{wr_idx, wr_way, wr_beat}] <= wr_data;
    end
endmodule

// File: rtl/l1d_refill_fsm.sv
module l1d_refill_fsm
    import l1d_refill_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 6,
    parameter int IDX_W    = 7,
    parameter int WAY_W    = 2,
    parameter int BEATS    = 4,
    parameter int BEAT_W   = 128,
    parameter int WORD_W   = 64,
    parameter int TAG_W    = ADDR_W - OFF_W - IDX_W,
    parameter int BEAT_IW  = $clog2(BEATS),
    parameter int BEAT_LSB = $clog2(BEAT_W / 8),
    parameter int WORD_LSB = $clog2(WORD_W / 8)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    lk_hit,
    input  logic [WAY_W-1:0]        lk_victim,
    input  logic [BEAT_W-1:0]       hit_beat,
    output logic                    rsp_valid,
    output logic [WORD_W-1:0]       rsp_data,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [ADDR_W-OFF_W-1:0] mem_req_line,
    output logic [BEAT_IW-1:0]      mem_req_crit,
    input  logic                    mem_beat_valid,
    input  logic [BEAT_W-1:0]       mem_beat_data,
    output logic                    wr_en,
    output logic [IDX_W-1:0]        wr_idx,
    output logic [WAY_W-1:0]        wr_way,
    output logic [BEAT_IW-1:0]      wr_beat,
    output logic                    ins_en,
    output logic [IDX_W-1:0]        ins_idx,
    output logic [WAY_W-1:0]        ins_way,
    output logic [TAG_W-1:0]        ins_tag
);
    localparam int                 WSEL_W   = BEAT_LSB - WORD_LSB;
    localparam logic [BEAT_IW-1:0] LAST_CNT = BEAT_IW'(BEATS - 1);
    localparam logic [BEAT_IW-1:0] CNT_ONE  = BEAT_IW'(1);

    fill_state_e        state_q, state_d;
    logic [ADDR_W-1:0]  addr_q;
    logic [WAY_W-1:0]   way_q;
    logic [BEAT_IW-1:0] cnt_q;
    logic               accept;
    logic [WSEL_W-1:0]  hit_sel, crit_sel;
    logic [WORD_W-1:0]  hit_word, crit_word;

    assign hit_sel   = req_addr[BEAT_LSB-1:WORD_LSB];
    assign crit_sel  = addr_q[BEAT_LSB-1:WORD_LSB];
    assign hit_word  = hit_beat[int'(hit_sel) * WORD_W +: WORD_W];
    assign crit_word = mem_beat_data[int'(crit_sel) * WORD_W +: WORD_W];

    assign mem_req_line = addr_q[ADDR_W-1:OFF_W];
    assign mem_req_crit = addr_q[OFF_W-1:BEAT_LSB];
    assign wr_idx       = addr_q[OFF_W+IDX_W-1:OFF_W];
    assign wr_way       = way_q;
    assign wr_beat      = mem_req_crit + cnt_q;
    assign ins_idx      = wr_idx;
    assign ins_way      = way_q;
    assign ins_tag      = addr_q[ADDR_W-1:OFF_W+IDX_W];
    assign accept       = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d       = state_q;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        wr_en         = 1'b0;
        ins_en        = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid && !lk_hit) state_d = S_ISSUE;
            end
            S_ISSUE: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) state_d = S_FILL;
            end
            S_FILL: begin
                if (mem_beat_valid) begin
                    wr_en = 1'b1;
                    if (cnt_q == LAST_CNT) begin
                        ins_en  = 1'b1;
                        state_d = S_IDLE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            way_q     <= '0;
            cnt_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                addr_q <= req_addr;
                way_q  <= lk_victim;
                cnt_q  <= '0;
                if (lk_hit) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= hit_word;
                end
            end
            if (wr_en) begin
                cnt_q <= cnt_q + CNT_ONE;
                if (cnt_q == '0) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= crit_word;
                end
            end
        end
    end

    // R4: an outstanding line request holds its fields until taken
    a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_line) && $stable(mem_req_crit)));
endmodule

// File: rtl/l1d_refill_ctrl.sv
module l1d_refill_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 64,
    parameter int BEAT_W     = 128,
    parameter int WORD_W     = 64,
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int BEAT_IW    = $clog2(LINE_BYTES * 8 / BEAT_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    rsp_valid,
    output logic [WORD_W-1:0]       rsp_data,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [ADDR_W-OFF_W-1:0] mem_req_line,
    output logic [BEAT_IW-1:0]      mem_req_crit,
    input  logic                    mem_beat_valid,
    input  logic [BEAT_W-1:0]       mem_beat_data
);
    localparam int IDX_W    = $clog2(SETS);
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W    = $clog2(WAYS);
    localparam int BEATS    = LINE_BYTES * 8 / BEAT_W;
    localparam int BEAT_LSB = $clog2(BEAT_W / 8);

    logic               lk_hit;
    logic [WAY_W-1:0]   lk_hit_way, lk_victim;
    logic [BEAT_W-1:0]  hit_beat;
    logic               wr_en, ins_en;
    logic [IDX_W-1:0]   wr_idx, ins_idx;
    logic [WAY_W-1:0]   wr_way, ins_way;
    logic [BEAT_IW-1:0] wr_beat;
    logic [TAG_W-1:0]   ins_tag;

    l1d_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (req_addr[OFF_W+IDX_W-1:OFF_W]),
        .lk_tag    (req_addr[ADDR_W-1:OFF_W+IDX_W]),
        .lk_hit    (lk_hit),
        .lk_hit_way(lk_hit_way),
        .lk_victim (lk_victim),
        .ins_en    (ins_en),
        .ins_idx   (ins_idx),
        .ins_way   (ins_way),
        .ins_tag   (ins_tag)
    );

    l1d_line_data #(
        .SETS(SETS), .WAYS(WAYS), .BEATS(BEATS), .BEAT_W(BEAT_W),
        .IDX_W(IDX_W), .WAY_W(WAY_W), .BEAT_IW(BEAT_IW)
    ) u_data (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_way (wr_way),
        .wr_beat(wr_beat),
        .wr_data(mem_beat_data),
        .rd_idx (req_addr[OFF_W+IDX_W-1:OFF_W]),
        .rd_way (lk_hit_way),
        .rd_beat(req_addr[OFF_W-1:BEAT_LSB]),
        .rd_data(hit_beat)
    );

    l1d_refill_fsm #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .WAY_W(WAY_W),
        .BEATS(BEATS), .BEAT_W(BEAT_W), .WORD_W(WORD_W), .TAG_W(TAG_W),
        .BEAT_IW(BEAT_IW)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .lk_hit        (lk_hit),
        .lk_victim     (lk_victim),
        .hit_beat      (hit_beat),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_line  (mem_req_line),
        .mem_req_crit  (mem_req_crit),
        .mem_beat_valid(mem_beat_valid),
        .mem_beat_data (mem_beat_data),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_way        (wr_way),
        .wr_beat       (wr_beat),
        .ins_en        (ins_en),
        .ins_idx       (ins_idx),
        .ins_way       (ins_way),
        .ins_tag       (ins_tag)
    );

    // R8: installing the line ends the fill and reopens the request port
    a_r8_install_reopens: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> req_ready);

    // R9: no line request is outstanding while a request can be taken
    a_r9_ready_excludes_issue: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);
endmodule

// File: tb/tb_l1d_refill_ctrl.sv
module tb_l1d_refill_ctrl;
    localparam int AW = 16;
    localparam int NS = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [AW-1:0] req_addr = '0;
    logic         rsp_valid;
    logic [63:0]  rsp_data;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [AW-7:0] mem_req_line;
    logic [1:0]   mem_req_crit;
    logic         mem_beat_valid = 1'b0;
    logic [127:0] mem_beat_data = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit exp_rsp = 0;
    logic [63:0] exp_data = '0;
    string exp_tag = "R3";
    logic [31:0] seed = 32'h1234_5678;

    bit m_val [NS][4];
    int m_tag [NS][4];
    int m_rr  [NS];

    always #5 clk = ~clk;

    l1d_refill_ctrl #(.ADDR_W(AW), .SETS(NS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_line(mem_req_line), .mem_req_crit(mem_req_crit),
        .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data)
    );

    function automatic logic [127:0] beat_of(int line, int b);
        logic [31:0] l;
        l = 32'(line);
        return {l ^ 32'h1111_0000, 32'h5A00_0000 + 32'(b) * 32'h0101,
                l * 32'd3 + 32'(b), ~l ^ 32'(b)};
    endfunction

    function automatic logic [63:0] word_of(logic [AW-1:0] a);
        logic [127:0] bt;
        bt = beat_of(int'(a[AW-1:6]), int'(a[5:4]));
        return a[3] ? bt[127:64] : bt[63:0];
    endfunction

    function automatic bit resident(logic [AW-1:0] a);
        int s;
        s = int'(a[7:6]);
        for (int w = 0; w < 4; w++)
            if (m_val[s][w] && m_tag[s][w] == int'(a[AW-1:8])) return 1;
        return 0;
    endfunction

    function automatic void install(logic [AW-1:0] a);
        int s;
        int v;
        s = int'(a[7:6]);
        v = -1;
        for (int w = 0; w < 4; w++)
            if (v < 0 && !m_val[s][w]) v = w;
        if (v < 0) v = m_rr[s];
        m_val[s][v] = 1;
        m_tag[s][v] = int'(a[AW-1:8]);
        m_rr[s] = (m_rr[s] + 1) % 4;
    endfunction

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        exp_rsp = 0;
    endtask

    // reference comparison of the load-return port on every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(exp_tag, "rsp_valid", 64'(rsp_valid), 64'(exp_rsp));
            if (exp_rsp) check(exp_tag, "rsp_data", rsp_data, exp_data);
        end
    end

    task automatic do_load(logic [AW-1:0] a, int hold, bit gap, bit poke);
        bit hit;
        logic [AW-7:0] line;
        int crit;
        hit = resident(a);
        line = a[AW-1:6];
        crit = int'(a[5:4]);
        req_valid = 1;
        req_addr = a;
        check("R9", "ready before accept", 64'(req_ready), 64'd1);
        step();
        req_valid = 0;
        check("R3/R7", "miss flagged", 64'(mem_req_valid), 64'(!hit));
        if (hit) begin
            exp_tag = "R3";
            exp_rsp = 1;
            exp_data = word_of(a);
            return;
        end
        check("R4", "line addr", 64'(mem_req_line), 64'(line));
        check("R4", "crit beat", 64'(mem_req_crit), 64'(crit));
        check("R9", "ready during issue", 64'(req_ready), 64'd0);
        if (poke) begin
            req_valid = 1;
            req_addr = a ^ 16'h0008;
        end
        for (int k = 0; k < hold; k++) begin
            step();
            check("R4", "request held", 64'(mem_req_valid), 64'd1);
            check("R4", "line stable", 64'(mem_req_line), 64'(line));
            check("R9", "stalled", 64'(req_ready), 64'd0);
        end
        mem_req_ready = 1;
        step();
        mem_req_ready = 0;
        check("R4", "request dropped", 64'(mem_req_valid), 64'd0);
        for (int n = 0; n < 4; n++) begin
            if (gap && n == 1) step();
            mem_beat_valid = 1;
            mem_beat_data = beat_of(int'(line), (crit + n) % 4);
            step();
            mem_beat_valid = 0;
            if (n == 0) begin
                exp_tag = "R6";
                exp_rsp = 1;
                exp_data = word_of(a);
            end
            check(n == 3 ? "R8" : "R9", "ready after beat", 64'(req_ready), 64'(n == 3));
        end
        req_valid = 0;
        install(a);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        for (int s = 0; s < NS; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < 4; w++) begin
                m_val[s][w] = 0;
                m_tag[s][w] = 0;
            end
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step();
        check("R1", "ready", 64'(req_ready), 64'd1);
        check("R1", "rsp", 64'(rsp_valid), 64'd0);
        check("R1", "mem req", 64'(mem_req_valid), 64'd0);
        // R1 R2 R5 R6: first miss, critical beat 2, upper half
        base = {8'h21, 2'd0, 6'h00};
        do_load(base | 16'h0028, 1, 0, 0);
        // R5 R8: every word of the wrapped line now hits
        for (int o = 0; o < 8; o++) do_load(base | 16'(o * 8), 0, 0, 0);
        // R7: fill set 1 and force round-robin evictions
        for (int t = 0; t < 7; t++)
            do_load({8'(16 + t), 2'd1, 6'(t * 8 + 8)}, t % 3, t[0], t[1]);
        for (int t = 0; t < 7; t++)
            do_load({8'(16 + t), 2'd1, 6'h30}, 0, 0, 0);
        // R2: same tag in different sets are separate lines
        for (int s = 0; s < NS; s++) do_load({8'h55, 2'(s), 6'h18}, 0, 1, 0);
        for (int s = 0; s < NS; s++) do_load({8'h55, 2'(s), 6'h20}, 0, 0, 0);
        // mixed traffic
        for (int i = 0; i < 250; i++) begin
            logic [31:0] r;
            r = rnd();
            do_load({8'(r[2:0] % 6), r[4:3], r[7:5], 3'b000},
                    int'(r[9:8]) % 3, r[10], r[11]);
        end
        step();
        step();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule